// File: doc/BRIEF.md
# Operand Hazard Interlock and Forwarding Control

This block is the hazard control for a four-segment in-order instruction pipeline: fetch, decode with effective-address calculation, operand fetch, and execute with register writeback. Instruction and data memories are separate. The block keeps a shadow of the register fields of every instruction in decode, operand fetch and execute. Each cycle it compares the two source register numbers of the instruction in operand fetch against the destination of the instruction in execute. A result computed in execute is steered to the dependent operand through a forwarding multiplexer. A result that comes back from a data-memory load is not ready in time, so the block holds fetch, decode and operand fetch for one cycle and sends a bubble into execute. Program order never changes.

A taken branch resolves in execute. When it does, the block raises `flush`, and the two younger instructions in decode and operand fetch are discarded along with the one being fetched. All hazard outputs are combinational functions of the current stage registers. A small controller records whether the pipeline is running normally, sitting in the interlock cycle or refilling after a flush. Its states are ST_RUN, ST_INTERLOCK, ST_DRAIN1 and ST_DRAIN2. Its transitions are: RUN to INTERLOCK on a load-use stall; RUN or INTERLOCK to DRAIN1 on a flush; INTERLOCK to RUN otherwise; DRAIN1 to DRAIN2; DRAIN2 to RUN. RUN stays in RUN when there is no event.

The fetch side offers one instruction per cycle on the `in_*` ports. That instruction is consumed at the rising edge unless `stall_fetch` or `flush` is high. An instruction consumed at edge k sits in decode in the next cycle, in operand fetch one cycle later and in execute one cycle after that.

Top module: `hz_interlock_unit`

## Requirements
- R1: After reset all six outputs are low, and they stay low until a valid instruction reaches execute.
- R2: When the instruction in execute is valid, has its write bit set, is not a load, and has a destination that is nonzero and equal to the first source of the valid instruction in operand fetch, `fwd_sel_a` is 1 (execute result). Otherwise it is 0 (register file). No stall occurs in that case.
- R3: Under the same conditions, applied to the second source, `fwd_sel_b` is 1. The two selects are decided independently, so both can be 1 together.
- R4: When the instruction in execute is a writing load whose nonzero destination equals either source of the operand-fetch instruction, `stall_fetch`, `stall_decode` and `bubble_opfetch` are high together for exactly one cycle with both forwarding selects low. In the next cycle execute holds a bubble and all hazard outputs are low.
- R5: Register 0 never causes a forward or a stall, whatever the write and load bits are.
- R6: An instruction with its write bit clear, or one presented with `in_valid` low, never causes a forward or a stall. An invalid consumer is never forwarded to.
- R7: `flush` is high exactly when execute holds a valid instruction with the branch bit set while `br_cond` is 1. The instructions then in decode and operand fetch never reach execute, so they cause no later forward, stall or flush.
- R8: When `flush` and a load-use match occur in the same cycle, `flush` is high and all three stall outputs are low.
- R9: During a stall the instructions in decode and operand fetch are kept. Once the stall ends, each one reaches execute in order and its own dependencies are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch offers a real instruction |
| in_src_a | input | 3 | First source register number |
| in_src_b | input | 3 | Second source register number |
| in_dst | input | 3 | Destination register number |
| in_wr | input | 1 | Instruction writes its destination |
| in_load | input | 1 | Result comes from a data-memory load |
| in_branch | input | 1 | Instruction is a conditional branch |
| br_cond | input | 1 | Branch condition of the instruction in execute is true |
| stall_fetch | output | 1 | Hold the fetch segment this cycle |
| stall_decode | output | 1 | Hold the decode segment this cycle |
| bubble_opfetch | output | 1 | Operand fetch holds and sends a bubble to execute |
| fwd_sel_a | output | 1 | First operand select: 1 execute result, 0 register file |
| fwd_sel_b | output | 1 | Second operand select: 1 execute result, 0 register file |
| flush | output | 1 | Discard all younger instructions (taken branch) |

## Verification
The assertions assume that fetch keeps the offered instruction unchanged while `stall_fetch` is high and redirects after `flush`. They also assume that `br_cond` only matters when execute holds a branch. The bench meets both conditions by offering only bubbles in any cycle where a stall or flush can occur, so the held value never differs from the offered one. An exhaustive sweep pairs every producer destination, write bit and load bit with every pair of consumer sources. Directed sequences cover chained dependencies across a stall, discarded wrong-path instructions, an untaken branch, and a flush coinciding with a load match.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

    parameter int unsigned REG_IDX_W = 3;
    parameter int unsigned NUM_SRC   = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    // instruction fields tracked in decode and operand fetch
    typedef struct packed {
        logic     valid;
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
        logic     wr;
        logic     load;
        logic     branch;
    } instr_slot_t;

    // fields still needed once an instruction sits in execute
    typedef struct packed {
        logic     valid;
        reg_idx_t dst;
        logic     wr;
        logic     load;
        logic     branch;
    } exe_slot_t;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_INTERLOCK = 2'd1,
        ST_DRAIN1    = 2'd2,
        ST_DRAIN2    = 2'd3
    } ctrl_state_t;

    typedef enum logic {
        FWD_REGFILE = 1'b0,
        FWD_EXEC    = 1'b1
    } fwd_sel_t;

endpackage

// File: rtl/hz_stage_track.sv
`timescale 1ns/1ps
module hz_stage_track
    import hz_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  instr_slot_t in_slot,
    input  logic        hold,
    input  logic        kill,
    output logic        opf_valid,
    output reg_idx_t    opf_src_a,
    output reg_idx_t    opf_src_b,
    output exe_slot_t   exe_q
);

    instr_slot_t dec_q;
    instr_slot_t opf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
            opf_q <= '0;
            exe_q <= '0;
        end else if (kill) begin
            // taken branch leaves execute; everything younger is dropped
            dec_q <= '0;
            opf_q <= '0;
            exe_q <= '0;
        end else if (hold) begin
            // decode and operand fetch keep their instructions, bubble to execute
            exe_q <= '0;
        end else begin
            dec_q        <= in_slot;
            opf_q        <= dec_q;
            exe_q.valid  <= opf_q.valid;
            exe_q.dst    <= opf_q.dst;
            exe_q.wr     <= opf_q.wr;
            exe_q.load   <= opf_q.load;
            exe_q.branch <= opf_q.branch;
        end
    end

    assign opf_valid = opf_q.valid;
    assign opf_src_a = opf_q.src_a;
    assign opf_src_b = opf_q.src_b;

endmodule

// File: rtl/hz_src_compare.sv
`timescale 1ns/1ps
module hz_src_compare
    import hz_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC
) (
    input  logic                 opf_valid,
    input  reg_idx_t [N_SRC-1:0] opf_src,
    input  exe_slot_t            exe_q,
    output logic     [N_SRC-1:0] fwd_hit,
    output logic                 load_hit
);

    logic             producer_ok;
    logic [N_SRC-1:0] src_match;

    // register 0 is hard-wired and never carries a dependency
    assign producer_ok = opf_valid && exe_q.valid && exe_q.wr &&
                         (exe_q.dst != reg_idx_t'(0));

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_match[g] = producer_ok && (opf_src[g] == exe_q.dst);
        assign fwd_hit[g]   = src_match[g] && !exe_q.load;
    end

    assign load_hit = (|src_match) && exe_q.load;

endmodule

// File: rtl/hz_ctrl_fsm.sv
`timescale 1ns/1ps
module hz_ctrl_fsm
    import hz_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_hit,
    input  logic        branch_hit,
    output logic        stall,
    output logic        kill,
    output logic        fwd_enable,
    output ctrl_state_t state_q
);

    ctrl_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs: flush wins over the interlock
    always_comb begin
        kill       = branch_hit;
        stall      = load_hit && !branch_hit;
        fwd_enable = 1'b0;
        unique case (state_q)
            ST_RUN:       fwd_enable = 1'b1;
            ST_INTERLOCK: fwd_enable = 1'b0;
            ST_DRAIN1:    fwd_enable = 1'b0;
            ST_DRAIN2:    fwd_enable = 1'b0;
        endcase
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (kill)       state_d = ST_DRAIN1;
                else if (stall) state_d = ST_INTERLOCK;
                else            state_d = ST_RUN;
            end
            ST_INTERLOCK: begin
                if (kill) state_d = ST_DRAIN1;
                else      state_d = ST_RUN;
            end
            ST_DRAIN1: state_d = ST_DRAIN2;
            ST_DRAIN2: state_d = ST_RUN;
        endcase
    end

endmodule

// File: rtl/hz_interlock_unit.sv
`timescale 1ns/1ps
module hz_interlock_unit
    import hz_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [REG_IDX_W-1:0] in_src_a,
    input  logic [REG_IDX_W-1:0] in_src_b,
    input  logic [REG_IDX_W-1:0] in_dst,
    input  logic                 in_wr,
    input  logic                 in_load,
    input  logic                 in_branch,
    input  logic                 br_cond,
    output logic                 stall_fetch,
    output logic                 stall_decode,
    output logic                 bubble_opfetch,
    output logic                 fwd_sel_a,
    output logic                 fwd_sel_b,
    output logic                 flush
);

    instr_slot_t           in_slot;
    logic                  opf_valid;
    reg_idx_t              opf_src_a;
    reg_idx_t              opf_src_b;
    reg_idx_t [NUM_SRC-1:0] opf_src;
    exe_slot_t             exe_q;
    logic [NUM_SRC-1:0]    fwd_hit;
    logic                  load_hit;
    logic                  branch_hit;
    logic                  stall;
    logic                  kill;
    logic                  fwd_enable;
    ctrl_state_t           fsm_state;

    always_comb begin
        in_slot.valid  = in_valid;
        in_slot.src_a  = in_src_a;
        in_slot.src_b  = in_src_b;
        in_slot.dst    = in_dst;
        in_slot.wr     = in_wr;
        in_slot.load   = in_load;
        in_slot.branch = in_branch;
    end

    hz_stage_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_slot   (in_slot),
        .hold      (stall),
        .kill      (kill),
        .opf_valid (opf_valid),
        .opf_src_a (opf_src_a),
        .opf_src_b (opf_src_b),
        .exe_q     (exe_q)
    );

    assign opf_src[0] = opf_src_a;
    assign opf_src[1] = opf_src_b;

    hz_src_compare #(.N_SRC(NUM_SRC)) u_cmp (
        .opf_valid (opf_valid),
        .opf_src   (opf_src),
        .exe_q     (exe_q),
        .fwd_hit   (fwd_hit),
        .load_hit  (load_hit)
    );

    assign branch_hit = exe_q.valid && exe_q.branch && br_cond;

    hz_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_hit   (load_hit),
        .branch_hit (branch_hit),
        .stall      (stall),
        .kill       (kill),
        .fwd_enable (fwd_enable),
        .state_q    (fsm_state)
    );

    assign stall_fetch    = stall;
    assign stall_decode   = stall;
    assign bubble_opfetch = stall;
    assign flush          = kill;
    assign fwd_sel_a      = fwd_enable && fwd_hit[0];
    assign fwd_sel_b      = fwd_enable && fwd_hit[1];

endmodule

// File: rtl/hz_interlock_checker.sv
`timescale 1ns/1ps
module hz_interlock_checker
    import hz_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        stall_fetch,
    input logic        stall_decode,
    input logic        bubble_opfetch,
    input logic        fwd_sel_a,
    input logic        fwd_sel_b,
    input logic        flush,
    input ctrl_state_t fsm_state
);

    assert_stall_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fetch |-> (stall_decode && bubble_opfetch));

    assert_stall_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_decode |=> !stall_decode);

    assert_stall_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_opfetch |-> (!fwd_sel_a && !fwd_sel_b));

    assert_interlock_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_INTERLOCK) |-> (!stall_decode && !flush));

    assert_flush_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!stall_fetch && !stall_decode && !bubble_opfetch));

    assert_flush_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    assert_drain_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state == ST_DRAIN1) || (fsm_state == ST_DRAIN2)) |-> (!flush && !stall_fetch));

endmodule

bind hz_interlock_unit hz_interlock_checker u_hz_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall_fetch    (stall_fetch),
    .stall_decode   (stall_decode),
    .bubble_opfetch (bubble_opfetch),
    .fwd_sel_a      (fwd_sel_a),
    .fwd_sel_b      (fwd_sel_b),
    .flush          (flush),
    .fsm_state      (fsm_state)
);

// File: tb/hz_interlock_unit_bench.sv
`timescale 1ns/1ps
module hz_interlock_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_src_a = '0;
    logic [2:0] in_src_b = '0;
    logic [2:0] in_dst = '0;
    logic       in_wr = 1'b0;
    logic       in_load = 1'b0;
    logic       in_branch = 1'b0;
    logic       br_cond = 1'b0;
    logic       stall_fetch, stall_decode, bubble_opfetch;
    logic       fwd_sel_a, fwd_sel_b, flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hz_interlock_unit u_hz_interlock_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .in_wr(in_wr), .in_load(in_load),
        .in_branch(in_branch), .br_cond(br_cond), .stall_fetch(stall_fetch),
        .stall_decode(stall_decode), .bubble_opfetch(bubble_opfetch),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .flush(flush)
    );

    // order: flush, stall_fetch, stall_decode, bubble_opfetch, fwd_sel_a, fwd_sel_b
    wire [5:0] obs = {flush, stall_fetch, stall_decode, bubble_opfetch, fwd_sel_a, fwd_sel_b};

    task automatic put(input logic v, input logic [2:0] sa, input logic [2:0] sb,
                       input logic [2:0] d, input logic w, input logic ld, input logic br);
        @(posedge clk);
        #1;
        in_valid = v; in_src_a = sa; in_src_b = sb; in_dst = d;
        in_wr = w; in_load = ld; in_branch = br;
    endtask

    task automatic bubble(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic check_obs(input logic [5:0] exp, input string tag);
        @(negedge clk);
        checks++;
        if (obs !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", tag, obs, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running expected finished");
        finish_run();
    end

    initial begin
        logic [5:0] e3;
        logic       hit_a, hit_b, prod_ok;
        string      tag;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_obs(6'b000000, "R1 after reset");
        bubble(4);
        check_obs(6'b000000, "R1 idle pipeline");

        // exhaustive producer x consumer sweep
        for (int d = 0; d < 8; d++)
        for (int w = 0; w < 2; w++)
        for (int ld = 0; ld < 2; ld++)
        for (int sa = 0; sa < 8; sa++)
        for (int sb = 0; sb < 8; sb++) begin
            prod_ok = (w == 1) && (d != 0);
            hit_a   = prod_ok && (sa == d);
            hit_b   = prod_ok && (sb == d);
            if (ld == 1) e3 = (hit_a || hit_b) ? 6'b011100 : 6'b000000;
            else         e3 = {4'b0000, hit_a, hit_b};
            if (d == 0)       tag = "R5 reg0";
            else if (w == 0)  tag = "R6 nowrite";
            else if (ld == 1) tag = "R4 load";
            else              tag = "R2 R3 fwd";
            put(1'b1, 3'd0, 3'd0, 3'(d), w[0], ld[0], 1'b0);
            put(1'b1, 3'(sa), 3'(sb), 3'd0, 1'b0, 1'b0, 1'b0);
            put(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
            check_obs(6'b000000, {tag, " cycle2"});
            bubble(1);
            check_obs(e3, {tag, " cycle3"});
            bubble(1);
            check_obs(6'b000000, {tag, " cycle4"});
            bubble(2);
        end

        // R9: chain across a load stall
        put(1'b1, 3'd0, 3'd0, 3'd1, 1'b1, 1'b1, 1'b0);
        put(1'b1, 3'd1, 3'd0, 3'd2, 1'b1, 1'b0, 1'b0);
        put(1'b1, 3'd0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0);
        bubble(1);
        check_obs(6'b011100, "R9 R4 stall on load");
        bubble(1);
        check_obs(6'b000000, "R9 R4 after stall");
        bubble(1);
        check_obs(6'b000001, "R9 held instruction forwards");
        bubble(3);

        // R7: taken branch discards writer and reader
        br_cond = 1'b1;
        put(1'b1, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1);
        put(1'b1, 3'd0, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0);
        put(1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        bubble(1);
        check_obs(6'b100000, "R7 flush raised");
        bubble(1);
        check_obs(6'b000000, "R7 wrong path gone c4");
        bubble(1);
        check_obs(6'b000000, "R7 wrong path gone c5");
        bubble(3);

        // R7: untaken branch keeps younger instructions
        br_cond = 1'b0;
        put(1'b1, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1);
        put(1'b1, 3'd0, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0);
        put(1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        bubble(1);
        check_obs(6'b000000, "R7 untaken no flush");
        bubble(1);
        check_obs(6'b000010, "R7 untaken forwards");
        bubble(3);

        // R8: flush and load match together
        br_cond = 1'b1;
        put(1'b1, 3'd0, 3'd0, 3'd4, 1'b1, 1'b1, 1'b1);
        put(1'b1, 3'd4, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        bubble(1);
        check_obs(6'b000000, "R8 before execute");
        bubble(1);
        check_obs(6'b100000, "R8 flush over stall");
        bubble(1);
        check_obs(6'b000000, "R8 after flush");
        bubble(3);
        br_cond = 1'b0;

        // R6: invalid producer, invalid consumer
        put(1'b0, 3'd0, 3'd0, 3'd5, 1'b1, 1'b0, 1'b0);
        put(1'b1, 3'd5, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0);
        bubble(2);
        check_obs(6'b000000, "R6 invalid producer");
        bubble(3);
        put(1'b1, 3'd0, 3'd0, 3'd6, 1'b1, 1'b1, 1'b0);
        put(1'b0, 3'd6, 3'd6, 3'd0, 1'b0, 1'b0, 1'b0);
        bubble(2);
        check_obs(6'b000000, "R6 invalid consumer");
        bubble(3);

        finish_run();
    end

endmodule